// File: doc/BRIEF.md
# Packed-Control Event Counter Bank

This block is a small bank of free-running 32-bit event counters for an uncore performance monitor. Logic being monitored sends it single-cycle event pulses. Software programs one shared control word that holds a byte lane per counter. The 5-bit field in each lane chooses what that counter counts.

A counter runs only while its field holds an implemented event code. There is no separate enable bit: writing a zero field stops the counter. Each counter also has its own data word, which software reads and overwrites (normally with zero when it starts a measurement).

Counters raise no overflow flag. They wrap modulo 2^32, and software must sample them often enough to see every wrap. Access is through a plain 32-bit register bus. Writes take effect at the clock edge, and reads return data one cycle after the request.

Top module: `evctr_bank`

## Requirements
- R1: After reset every counter reads 0, the control word reads 0 and `bus_rvalid_o` is low.
- R2: The control word is at byte offset `CTL_OFS` (default 0x000). The code for counter n is at bits [8n+5:8n+1]. Bit 8n and bits [8n+7:8n+6] always read 0, and writes to those bits are discarded.
- R3: Each counter adds at most 1 per clock. Code 0x01 adds 1 on every clock. Code 0x0B adds 1 in cycles where `evt_i[0]` (write transaction) is high, code 0x0D where `evt_i[1]` (data transfer) is high, and code 0x0F where `evt_i[2]` (read transaction) is high.
- R4: A counter whose code field is 0x00 keeps its value whatever the event inputs do.
- R5: A counter whose code is not one of 0x01, 0x0B, 0x0D or 0x0F keeps its value. This includes every code from 0x10 to 0x1F.
- R6: A counter at 0xFFFFFFFF that counts once more becomes 0x00000000, and no other indication is given.
- R7: The data word of counter n is at byte offset `DATA_OFS + 12*n` (default 0x040, 0x04C, 0x058, 0x064). A write loads the written value into the counter, so writing 0 clears it.
- R8: If a data-word write and a counted event reach the same counter in the same cycle, the counter takes the written value and the event is lost.
- R9: A read request in cycle t makes `bus_rvalid_o` high in cycle t+1. `bus_rdata_o` then holds the value the addressed register had in cycle t. Reads change no state, and back-to-back reads are each answered.
- R10: A read of any other address returns 0. A write to any other address changes no counter and no code.
- R11: Counters programmed with the same code count independently: writing one counter's data word does not disturb another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | Event pulses: [0] write transaction, [1] data transfer, [2] read transaction |
| bus_sel_i | input | 1 | Bus request valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid (one cycle after a read request) |
| bus_rdata_o | output | 32 | Read data |

## Verification
The hardest case to reach from the ports is a data-word write landing in the same cycle as a counted event. Hitting it by chance with random events is unlikely. The stimulus therefore holds all three event lines high and programs the data-transfer code before it writes the data word, so the clash is certain.

A counter wrap is also hard to reach, because waiting 2^32 cycles is not practical. The bench preloads a value a few counts below the top and lets the cycle code carry it past zero.

Reserved control bits are covered by writing all ones to the control word. That write also sets every field to an invalid code, so the same step shows that counters with invalid codes hold their values.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    localparam int CODE_W  = 5;
    localparam int LANE_W  = 8;
    localparam int FLD_LSB = 1;
    localparam int EVT_SRC = 3;

    localparam logic [CODE_W-1:0] CODE_OFF    = 5'h00;
    localparam logic [CODE_W-1:0] CODE_CYCLES = 5'h01;
    localparam logic [CODE_W-1:0] CODE_WRTXN  = 5'h0B;
    localparam logic [CODE_W-1:0] CODE_XFER   = 5'h0D;
    localparam logic [CODE_W-1:0] CODE_RDTXN  = 5'h0F;

    // Decide whether a counter programmed with `code` advances this cycle.
    function automatic logic code_hits(input logic [CODE_W-1:0] code,
                                       input logic [EVT_SRC-1:0] evt);
        logic hit;
        case (code)
            CODE_CYCLES: hit = 1'b1;
            CODE_WRTXN:  hit = evt[0];
            CODE_XFER:   hit = evt[1];
            CODE_RDTXN:  hit = evt[2];
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/evctr_addr_dec.sv
module evctr_addr_dec #(
    parameter int          NUM_CTR     = 4,
    parameter int          ADDR_W      = 12,
    parameter int unsigned CTL_OFS     = 'h000,
    parameter int unsigned DATA_OFS    = 'h040,
    parameter int unsigned DATA_STRIDE = 'h00C
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               ctl_hit_o,
    output logic [NUM_CTR-1:0] data_hit_o
);

    assign ctl_hit_o = (addr_i == ADDR_W'(CTL_OFS));

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_dec
        localparam int unsigned SLOT_ADDR = DATA_OFS + DATA_STRIDE * n;
        assign data_hit_o[n] = (addr_i == ADDR_W'(SLOT_ADDR));
    end

endmodule

// File: rtl/evctr_evt_gate.sv
module evctr_evt_gate
    import evctr_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    input  logic [EVT_SRC-1:0] evt_i,
    output logic               inc_o
);

    always_comb begin
        inc_o = code_hits(code_i, evt_i);
    end

endmodule

// File: rtl/evctr_counter.sv
module evctr_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             ld_i,
    input  logic [CTR_W-1:0] ld_val_i,
    output logic [CTR_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;                  // software write wins
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + CTR_W'(1);      // silent modulo wrap
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int          NUM_CTR     = 4,
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 12,
    parameter int unsigned CTL_OFS     = 'h000,
    parameter int unsigned DATA_OFS    = 'h040,
    parameter int unsigned DATA_STRIDE = 'h00C
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [EVT_SRC-1:0] evt_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic               bus_rvalid_o,
    output logic [DATA_W-1:0]  bus_rdata_o
);

    typedef struct packed {
        logic [NUM_CTR-1:0][CODE_W-1:0] code;
        logic                           rvalid;
        logic [DATA_W-1:0]              rdata;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic                           ctl_hit;
    logic [NUM_CTR-1:0]             data_hit;
    logic [NUM_CTR-1:0]             inc;
    logic [NUM_CTR-1:0]             ld;
    logic [NUM_CTR-1:0][DATA_W-1:0] cnt_all;
    logic [NUM_CTR-1:0][CODE_W-1:0] code_q;
    logic [DATA_W-1:0]              ctl_word;
    logic [DATA_W-1:0]              rd_mux;
    logic                           wr_req;
    logic                           rd_req;

    assign wr_req = bus_sel_i &&  bus_wr_i;
    assign rd_req = bus_sel_i && !bus_wr_i;
    assign code_q = st_q.code;

    evctr_addr_dec #(
        .NUM_CTR     (NUM_CTR),
        .ADDR_W      (ADDR_W),
        .CTL_OFS     (CTL_OFS),
        .DATA_OFS    (DATA_OFS),
        .DATA_STRIDE (DATA_STRIDE)
    ) u_dec (
        .addr_i     (bus_addr_i),
        .ctl_hit_o  (ctl_hit),
        .data_hit_o (data_hit)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        assign ld[n] = wr_req && data_hit[n];

        evctr_evt_gate u_gate (
            .code_i (code_q[n]),
            .evt_i  (evt_i),
            .inc_o  (inc[n])
        );

        evctr_counter #(
            .CTR_W (DATA_W)
        ) u_cnt (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .inc_i    (inc[n]),
            .ld_i     (ld[n]),
            .ld_val_i (bus_wdata_i),
            .cnt_o    (cnt_all[n])
        );
    end

    // Control word as seen by software: reserved bits are tied low.
    always_comb begin
        ctl_word = '0;
        for (int n = 0; n < NUM_CTR; n++) begin
            ctl_word[n*LANE_W+FLD_LSB +: CODE_W] = code_q[n];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (ctl_hit) begin
            rd_mux = ctl_word;
        end
        for (int n = 0; n < NUM_CTR; n++) begin
            if (data_hit[n]) begin
                rd_mux = rd_mux | cnt_all[n];
            end
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_req;
        if (rd_req) begin
            st_d.rdata = rd_mux;
        end
        if (wr_req && ctl_hit) begin
            for (int n = 0; n < NUM_CTR; n++) begin
                st_d.code[n] = bus_wdata_i[n*LANE_W+FLD_LSB +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rvalid_o = st_q.rvalid;
    assign bus_rdata_o  = st_q.rdata;

endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
    parameter int          NUM_CTR = 4,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter int          CODE_W  = 5,
    parameter int unsigned CTL_OFS = 'h000
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic                           bus_sel_i,
    input logic                           bus_wr_i,
    input logic [ADDR_W-1:0]              bus_addr_i,
    input logic [DATA_W-1:0]              bus_wdata_i,
    input logic                           bus_rvalid_o,
    input logic [DATA_W-1:0]              bus_rdata_o,
    input logic [NUM_CTR-1:0][DATA_W-1:0] cnt_all,
    input logic [NUM_CTR-1:0][CODE_W-1:0] code_q,
    input logic [NUM_CTR-1:0]             ld
);

    // R9: read request answered exactly one cycle later
    p_rvalid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i) |=> bus_rvalid_o);

    p_no_spurious_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_sel_i && !bus_wr_i) |=> !bus_rvalid_o);

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
        // R2: reserved control bits read back low
        p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(CTL_OFS))
            |=> (bus_rdata_o[8*k] == 1'b0 && bus_rdata_o[8*k+7 -: 2] == 2'b00));

        // R8: a data write always lands, even with an event present
        p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ld[k] |=> (cnt_all[k] == $past(bus_wdata_i)));

        // R3: never more than one count per clock
        p_step_le1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ld[k] |=> (cnt_all[k] == $past(cnt_all[k]) ||
                        cnt_all[k] == $past(cnt_all[k]) + DATA_W'(1)));

        // R4: zero code holds the counter
        p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ld[k] && code_q[k] == '0) |=> $stable(cnt_all[k]));

        // R5: codes at or above 0x10 hold the counter
        p_invalid_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!ld[k] && code_q[k][CODE_W-1]) |=> $stable(cnt_all[k]));
    end

endmodule

bind evctr_bank evctr_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CODE_W  (evctr_pkg::CODE_W),
    .CTL_OFS (CTL_OFS)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_sel_i    (bus_sel_i),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .cnt_all      (cnt_all),
    .code_q       (code_q),
    .ld           (ld)
);

// File: tb/evctr_bank_bench.sv
module evctr_bank_bench;

    localparam int NCTR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    evctr_bank u_evctr_bank (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .evt_i        (evt),
        .bus_sel_i    (sel),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rvalid_o (rvalid),
        .bus_rdata_o  (rdata)
    );

    // Behavioural reference model
    logic [31:0] m_cnt  [NCTR];
    logic [4:0]  m_code [NCTR];
    logic [31:0] exp_q[$];
    bit          exp_rv;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          cyc = 0;
    string       cur_req = "R1";

    function automatic int slot_of(input logic [11:0] a);
        for (int n = 0; n < NCTR; n++) begin
            if (int'(a) == 'h40 + 12 * n) return n;
        end
        return -1;
    endfunction

    function automatic bit counts(input logic [4:0] c, input logic [2:0] e);
        case (c)
            5'h01:   return 1'b1;
            5'h0B:   return e[0];
            5'h0D:   return e[1];
            5'h0F:   return e[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] v;
        int s;
        v = '0;
        if (a == 12'h000) begin
            for (int n = 0; n < NCTR; n++) v[8*n+1 +: 5] = m_code[n];
        end
        s = slot_of(a);
        if (s >= 0) v = m_cnt[s];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCTR; n++) begin
                m_cnt[n]  = '0;
                m_code[n] = '0;
            end
            exp_q.delete();
            exp_rv = 1'b0;
        end else begin
            int s;
            exp_rv = sel && !wr;
            if (sel && !wr) exp_q.push_back(model_read(addr));
            s = (sel && wr) ? slot_of(addr) : -1;
            for (int n = 0; n < NCTR; n++) begin
                if (s == n)                         m_cnt[n] = wdata;
                else if (counts(m_code[n], evt))    m_cnt[n] = m_cnt[n] + 32'd1;
            end
            if (sel && wr && addr == 12'h000) begin
                for (int n = 0; n < NCTR; n++) m_code[n] = wdata[8*n+1 +: 5];
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (rvalid !== exp_rv) begin
                n_bad++;
                $display("FAIL %s: rvalid got %b exp %b", cur_req, rvalid, exp_rv);
            end
            if (exp_rv) begin
                logic [31:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata got %h exp %h", cur_req, rdata, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp finish");
            summary();
        end
    end

    // Stimulus tasks, each entered and left at a falling edge
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_evts(input int n);
        repeat (n) begin
            evt = 3'($urandom());
            @(negedge clk);
        end
        evt = '0;
    endtask

    task automatic read_all();
        bus_rd(12'h000);
        for (int n = 0; n < NCTR; n++) bus_rd(12'(32'h40 + 12 * n));
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";                          // reset state
        read_all();

        cur_req = "R2";                          // reserved bits dropped
        bus_wr(12'h000, 32'hFFFF_FFFF);
        bus_rd(12'h000);
        idle(1);

        cur_req = "R5";                          // all fields 0x1F: hold
        run_evts(20);
        read_all();

        cur_req = "R3";                          // each code on its source
        bus_wr(12'h000, 32'h1E1A_1602);
        for (int n = 0; n < NCTR; n++) bus_wr(12'(32'h40 + 12 * n), 32'h0);
        run_evts(40);
        read_all();
        for (int i = 0; i < 10; i++) begin
            evt = 3'($urandom());
            bus_rd(12'(32'h40 + 12 * (i % NCTR)));
        end
        evt = '0;

        cur_req = "R7";                          // load and clear
        bus_wr(12'h04C, 32'h1234_5678);
        bus_rd(12'h04C);
        bus_wr(12'h064, 32'h0);
        bus_rd(12'h064);
        idle(1);

        cur_req = "R4";                          // zero field on counter 1
        bus_wr(12'h000, 32'h1E1A_0002);
        run_evts(30);
        read_all();

        cur_req = "R5";                          // 0x05, 0x13, 0x10, 0x1F
        bus_wr(12'h000, 32'h3E20_260A);
        run_evts(30);
        read_all();

        cur_req = "R6";                          // wrap past zero
        bus_wr(12'h000, 32'h0000_0002);
        bus_wr(12'h040, 32'hFFFF_FFFD);
        bus_rd(12'h040);
        idle(4);
        bus_rd(12'h040);
        idle(1);

        cur_req = "R8";                          // write vs event, same cycle
        bus_wr(12'h000, 32'h001A_0000);
        evt = 3'b111;
        bus_wr(12'h058, 32'h0000_0055);
        bus_rd(12'h058);
        evt = '0;
        idle(1);

        cur_req = "R9";                          // back-to-back reads
        bus_wr(12'h000, 32'h0000_0002);
        sel = 1'b1; wr = 1'b0; addr = 12'h040;
        repeat (4) @(negedge clk);
        addr = 12'h000;
        @(negedge clk);
        sel = 1'b0;
        idle(2);

        cur_req = "R10";                         // unmapped addresses
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h100, 32'hFFFF_FFFF);
        bus_rd(12'h004);
        bus_rd(12'h100);
        bus_rd(12'h044);
        read_all();

        cur_req = "R11";                         // same code, independent
        bus_wr(12'h000, 32'h001A_001A);
        bus_wr(12'h040, 32'h0);
        bus_wr(12'h058, 32'h0);
        run_evts(20);
        bus_wr(12'h040, 32'h0);
        run_evts(20);
        read_all();

        idle(3);
        summary();
    end

endmodule